// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block sits behind the write path of a parallel NOR flash controller. It watches bus write cycles, one strobe per cycle with an address and a data word, and recognises the multi-cycle unlock sequences that select an operation. Sequences are qualified by address, and a data-cycle counter is not enough to follow them. The recognised operations are program, chip erase, sector erase, erase suspend and resume, entry to identification (autoselect) mode, entry to the parameter query (CFI) mode, and return to array reading. The block also enters and leaves an unlock-bypass mode. In that mode a program takes only two writes.

The decoder does not run the embedded algorithms. It reports each command as a one-cycle pulse. With the pulse it gives an opcode, plus the address and data of the write that completed the command. The opcode, address and data stay held until the next command. It also reports the read mode continuously, so that the read path can select between the array, identification codes and query data. An `erase_busy` input from the erase engine decides whether suspend and resume writes take effect.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `rd_mode` is 0 (array), `cmd_valid` is 0, `cmd_op` is 0 and `cmd_addr`/`cmd_data` are zero.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h followed by any write produce a PROGRAM pulse (`cmd_op`=1) that carries that last write's address and data. Only address bits 10:0 and data bits 7:0 are compared in command cycles.
- R3: After AAh@555h, 55h@2AAh and 80h@555h, the writes AAh@555h and 55h@2AAh are expected next. A sixth write of 10h@555h gives CHIP_ERASE (`cmd_op`=2). A sixth write of 30h at any address gives SECTOR_ERASE (`cmd_op`=3) carrying that address.
- R4: Unlock plus 90h@555h gives AUTOSEL (`cmd_op`=6) and sets `rd_mode`=1. In that mode, every write other than F0h and 98h@055h leaves the mode unchanged and gives no pulse.
- R5: A write of F0h at any address, in any position where a command byte is expected, gives RESET (`cmd_op`=8) and sets `rd_mode`=0. The exception is query mode, where F0h restores the mode that held before the query.
- R6: 98h@055h, issued from array mode (at sequence start) or from autoselect mode, gives CFI (`cmd_op`=7) and sets `rd_mode`=2.
- R7: Unlock plus 20h@555h gives BYPASS_ENTER (`cmd_op`=9) and sets `rd_mode`=3. In bypass mode, A0h at any address followed by any write gives a PROGRAM pulse.
- R8: In bypass mode, 90h followed by 00h (any addresses) gives BYPASS_EXIT (`cmd_op`=10) and sets `rd_mode`=0. Any other second byte returns to array mode with no pulse.
- R9: At the start of a sequence in array or bypass mode, B0h gives SUSPEND (`cmd_op`=4) and 30h gives RESUME (`cmd_op`=5), both only while `erase_busy` is 1. Otherwise these writes have no effect.
- R10: Any write that breaks a sequence abandons it with no pulse, and the decoder then expects a new sequence in array mode. In query mode, any write other than F0h sets `rd_mode`=0.
- R11: `cmd_valid` is high for exactly the cycle after the completing write. `cmd_op`, `cmd_addr` and `cmd_data` change only with a pulse. `rd_mode` changes only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one per write cycle |
| wr_addr | input | ADDR_W (22) | Write address |
| wr_data | input | DATA_W (16) | Write data |
| erase_busy | input | 1 | Erase engine is running a sector erase |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_op | output | 4 | Opcode of the last command |
| cmd_addr | output | ADDR_W (22) | Address of the completing write |
| cmd_data | output | DATA_W (16) | Data of the completing write |
| rd_mode | output | 2 | 0 array, 1 autoselect, 2 query, 3 bypass |

## Verification
The embedded assertions watch some properties on every cycle. A pulse always follows a write. The held opcode never moves without a pulse. Suspend and resume never appear without `erase_busy`. Autoselect is left only through a reset or query pulse. Bypass is entered only with its own pulse. Whether the right sequence produces the right opcode, address and data can only be shown by the bench's reference model, replayed over directed sequences and a long stream of command-heavy random writes. The same applies to deviations abandoning a sequence and query mode returning to the mode before it.

// File: rtl/ncd_pkg.sv
package ncd_pkg;

   typedef enum logic [3:0] {
      OP_NONE         = 4'd0,
      OP_PROGRAM      = 4'd1,
      OP_CHIP_ERASE   = 4'd2,
      OP_SECTOR_ERASE = 4'd3,
      OP_SUSPEND      = 4'd4,
      OP_RESUME       = 4'd5,
      OP_AUTOSEL      = 4'd6,
      OP_CFI          = 4'd7,
      OP_RESET        = 4'd8,
      OP_BYP_ENTER    = 4'd9,
      OP_BYP_EXIT     = 4'd10
   } ncd_op_e;

   typedef enum logic [1:0] {
      MD_ARRAY   = 2'd0,
      MD_AUTOSEL = 2'd1,
      MD_CFI     = 2'd2,
      MD_BYPASS  = 2'd3
   } ncd_mode_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_E3, ST_E4, ST_E5, ST_BP_PGM, ST_BP_EXIT
   } ncd_state_e;

   typedef struct packed {
      logic       a_555;
      logic       a_2aa;
      logic       a_055;
      logic [7:0] code;
   } ncd_cls_t;

   localparam logic [7:0] CD_UNLK_A  = 8'hAA;
   localparam logic [7:0] CD_UNLK_B  = 8'h55;
   localparam logic [7:0] CD_PROG    = 8'hA0;
   localparam logic [7:0] CD_IDENT   = 8'h90;
   localparam logic [7:0] CD_ERSETUP = 8'h80;
   localparam logic [7:0] CD_BYPASS  = 8'h20;
   localparam logic [7:0] CD_CHIP    = 8'h10;
   localparam logic [7:0] CD_SECT    = 8'h30;
   localparam logic [7:0] CD_SUSP    = 8'hB0;
   localparam logic [7:0] CD_RESET   = 8'hF0;
   localparam logic [7:0] CD_QUERY   = 8'h98;
   localparam logic [7:0] CD_BPEXIT  = 8'h00;

endpackage

// File: rtl/ncd_classify.sv
module ncd_classify
   import ncd_pkg::*;
#(
   parameter int CMP_W = 11
) (
   input  logic [CMP_W-1:0] addr_lo,
   input  logic [7:0]       code_in,
   output ncd_cls_t         cls
);

   localparam logic [CMP_W-1:0] K_555 = CMP_W'(16'h0555);
   localparam logic [CMP_W-1:0] K_2AA = CMP_W'(16'h02AA);
   localparam logic [CMP_W-1:0] K_055 = CMP_W'(16'h0055);

   generate
      if (CMP_W < 11) begin : g_bad_cmp
         $error("ncd_classify: CMP_W must cover the 555h key");
      end
   endgenerate

   always_comb begin
      cls.a_555 = (addr_lo == K_555);
      cls.a_2aa = (addr_lo == K_2AA);
      cls.a_055 = (addr_lo == K_055);
      cls.code  = code_in;
   end

endmodule

// File: rtl/ncd_seq.sv
module ncd_seq
   import ncd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  ncd_cls_t  cls,
   input  logic      erase_busy,
   output logic      fire,
   output ncd_op_e   fire_op,
   output ncd_mode_e mode
);

   ncd_state_e st_q, st_d;
   ncd_mode_e  md_q, md_d, ret_q, ret_d;
   logic       cfi_hit, susp_hit;

   assign cfi_hit  = cls.a_055 && (cls.code == CD_QUERY);
   assign susp_hit = (cls.code == CD_SUSP) || (cls.code == CD_SECT);
   assign mode     = md_q;

   always_comb begin
      st_d    = st_q;
      md_d    = md_q;
      ret_d   = ret_q;
      fire    = 1'b0;
      fire_op = OP_NONE;
      if (wr_en) begin
         if (st_q == ST_PGM || st_q == ST_BP_PGM) begin
            fire    = 1'b1;
            fire_op = OP_PROGRAM;
            st_d    = ST_IDLE;
         end else if (cls.code == CD_RESET) begin
            fire    = 1'b1;
            fire_op = OP_RESET;
            st_d    = ST_IDLE;
            md_d    = (md_q == MD_CFI) ? ret_q : MD_ARRAY;
         end else begin
            st_d = ST_IDLE;
            case (st_q)
               ST_IDLE: begin
                  case (md_q)
                     MD_AUTOSEL: begin
                        if (cfi_hit) begin
                           fire = 1'b1; fire_op = OP_CFI;
                           ret_d = MD_AUTOSEL; md_d = MD_CFI;
                        end
                     end
                     MD_CFI: md_d = MD_ARRAY;
                     MD_BYPASS: begin
                        if (cls.code == CD_PROG) st_d = ST_BP_PGM;
                        else if (cls.code == CD_IDENT) st_d = ST_BP_EXIT;
                        else if (susp_hit) begin
                           if (erase_busy) begin
                              fire = 1'b1;
                              fire_op = (cls.code == CD_SUSP) ? OP_SUSPEND : OP_RESUME;
                           end
                        end else md_d = MD_ARRAY;
                     end
                     default: begin
                        if (cls.a_555 && cls.code == CD_UNLK_A) st_d = ST_U1;
                        else if (cfi_hit) begin
                           fire = 1'b1; fire_op = OP_CFI;
                           ret_d = MD_ARRAY; md_d = MD_CFI;
                        end else if (susp_hit && erase_busy) begin
                           fire = 1'b1;
                           fire_op = (cls.code == CD_SUSP) ? OP_SUSPEND : OP_RESUME;
                        end
                     end
                  endcase
               end
               ST_U1: if (cls.a_2aa && cls.code == CD_UNLK_B) st_d = ST_U2;
               ST_U2: begin
                  if (cls.a_555) begin
                     case (cls.code)
                        CD_PROG:    st_d = ST_PGM;
                        CD_ERSETUP: st_d = ST_E3;
                        CD_IDENT: begin
                           fire = 1'b1; fire_op = OP_AUTOSEL; md_d = MD_AUTOSEL;
                        end
                        CD_BYPASS: begin
                           fire = 1'b1; fire_op = OP_BYP_ENTER; md_d = MD_BYPASS;
                        end
                        default: ;
                     endcase
                  end
               end
               ST_E3: if (cls.a_555 && cls.code == CD_UNLK_A) st_d = ST_E4;
               ST_E4: if (cls.a_2aa && cls.code == CD_UNLK_B) st_d = ST_E5;
               ST_E5: begin
                  if (cls.a_555 && cls.code == CD_CHIP) begin
                     fire = 1'b1; fire_op = OP_CHIP_ERASE;
                  end else if (cls.code == CD_SECT) begin
                     fire = 1'b1; fire_op = OP_SECTOR_ERASE;
                  end
               end
               ST_BP_EXIT: begin
                  md_d = MD_ARRAY;
                  if (cls.code == CD_BPEXIT) begin
                     fire = 1'b1; fire_op = OP_BYP_EXIT;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         md_q  <= MD_ARRAY;
         ret_q <= MD_ARRAY;
      end else begin
         st_q  <= st_d;
         md_q  <= md_d;
         ret_q <= ret_d;
      end
   end

   // R10: a pending program data cycle only exists in array or bypass mode
   a_r10_pgm_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PGM) |-> (md_q == MD_ARRAY));

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
   import ncd_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int DATA_W = 16,
   parameter int CMP_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              erase_busy,
   output logic              cmd_valid,
   output logic [3:0]        cmd_op,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   output logic [1:0]        rd_mode
);

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("nor_cmd_decoder: DATA_W must hold a command byte");
      end
      if (CMP_W > ADDR_W) begin : g_bad_addr
         $error("nor_cmd_decoder: CMP_W exceeds ADDR_W");
      end
   endgenerate

   ncd_cls_t  cls;
   logic      fire;
   ncd_op_e   fire_op;
   ncd_mode_e mode;

   ncd_classify #(.CMP_W(CMP_W)) u_cls (
      .addr_lo (wr_addr[CMP_W-1:0]),
      .code_in (wr_data[7:0]),
      .cls     (cls)
   );

   ncd_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .cls        (cls),
      .erase_busy (erase_busy),
      .fire       (fire),
      .fire_op    (fire_op),
      .mode       (mode)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_op    <= OP_NONE;
         cmd_addr  <= '0;
         cmd_data  <= '0;
      end else begin
         cmd_valid <= fire;
         if (fire) begin
            cmd_op   <= fire_op;
            cmd_addr <= wr_addr;
            cmd_data <= wr_data;
         end
      end
   end

   assign rd_mode = mode;

   a_r11_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(wr_en));

   a_r11_op_held: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> $stable(cmd_op));

   a_r11_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(rd_mode));

   a_r9_suspend_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == OP_SUSPEND || cmd_op == OP_RESUME)) |-> $past(erase_busy));

   a_r4_autosel_exit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_mode) == MD_AUTOSEL && rd_mode != MD_AUTOSEL)
         |-> (cmd_valid && (cmd_op == OP_RESET || cmd_op == OP_CFI)));

   a_r7_bypass_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_mode) != MD_BYPASS && rd_mode == MD_BYPASS)
         |-> (cmd_valid && cmd_op == OP_BYP_ENTER));

endmodule

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;

   localparam int AW = 22;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          erase_busy = 1'b0;
   logic          cmd_valid;
   logic [3:0]    cmd_op;
   logic [AW-1:0] cmd_addr;
   logic [DW-1:0] cmd_data;
   logic [1:0]    rd_mode;

   nor_cmd_decoder u_nor_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .erase_busy(erase_busy), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_mode(rd_mode)
   );

   always #10 clk = ~clk;

   int    n_cmp = 0;
   int    n_bad = 0;
   string req = "R1";
   bit    busy = 1'b0;

   // reference model state
   int          m_mode = 0;
   int          m_ret  = 0;
   int          hist[$];
   bit          e_valid = 1'b0;
   int          e_op = 0;
   logic [AW-1:0] e_addr = '0;
   logic [DW-1:0] e_data = '0;

   task automatic compare();
      n_cmp++;
      if (cmd_valid !== e_valid || int'(cmd_op) != e_op || int'(rd_mode) != m_mode
          || cmd_addr !== e_addr || cmd_data !== e_data) begin
         n_bad++;
         $display("FAIL %s: valid/op/mode/addr/data got %0d/%0d/%0d/%h/%h expected %0d/%0d/%0d/%h/%h",
                  req, cmd_valid, cmd_op, rd_mode, cmd_addr, cmd_data,
                  e_valid, e_op, m_mode, e_addr, e_data);
      end
   endtask

   task automatic pulse(int op, logic [AW-1:0] a, logic [DW-1:0] d);
      e_valid = 1'b1; e_op = op; e_addr = a; e_data = d;
   endtask

   task automatic model_write(logic [AW-1:0] a, logic [DW-1:0] d, bit bz);
      bit lo555 = (a[10:0] == 11'h555);
      bit lo2aa = (a[10:0] == 11'h2AA);
      bit lo055 = (a[10:0] == 11'h055);
      int c = int'(d[7:0]);
      int n = hist.size();
      bit ok;
      e_valid = 1'b0;
      if ((m_mode == 3 && n == 1 && hist[0] == 'hA0) ||
          (m_mode == 0 && n == 3 && hist[2] == 'hA0)) begin
         pulse(1, a, d); hist.delete();
      end else if (c == 'hF0) begin
         pulse(8, a, d); m_mode = (m_mode == 2) ? m_ret : 0; hist.delete();
      end else if (m_mode == 1) begin
         if (lo055 && c == 'h98) begin pulse(7, a, d); m_ret = 1; m_mode = 2; end
      end else if (m_mode == 2) begin
         m_mode = 0;
      end else if (m_mode == 3) begin
         if (n == 1) begin
            if (c == 0) pulse(10, a, d);
            m_mode = 0; hist.delete();
         end else if (c == 'hA0 || c == 'h90) hist.push_back(c);
         else if (c == 'hB0 || c == 'h30) begin
            if (bz) pulse((c == 'hB0) ? 4 : 5, a, d);
         end else m_mode = 0;
      end else if (n == 0 && !(lo555 && c == 'hAA)) begin
         if (lo055 && c == 'h98) begin pulse(7, a, d); m_ret = 0; m_mode = 2; end
         else if ((c == 'hB0 || c == 'h30) && bz) pulse((c == 'hB0) ? 4 : 5, a, d);
      end else begin
         case (n)
            0: ok = lo555 && c == 'hAA;
            1: ok = lo2aa && c == 'h55;
            2: ok = lo555 && (c == 'hA0 || c == 'h90 || c == 'h80 || c == 'h20);
            3: ok = lo555 && c == 'hAA && hist[2] == 'h80;
            4: ok = lo2aa && c == 'h55;
            default: ok = (lo555 && c == 'h10) || c == 'h30;
         endcase
         if (!ok) hist.delete();
         else begin
            hist.push_back(c);
            if (n == 2 && c == 'h90) begin pulse(6, a, d); m_mode = 1; hist.delete(); end
            else if (n == 2 && c == 'h20) begin pulse(9, a, d); m_mode = 3; hist.delete(); end
            else if (n == 5) begin pulse((c == 'h10 && lo555) ? 2 : 3, a, d); hist.delete(); end
         end
      end
   endtask

   task automatic step(bit en, logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      compare();
      wr_en = en; wr_addr = a; wr_data = d; erase_busy = busy;
      if (en) model_write(a, d, busy);
      else e_valid = 1'b0;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      step(1'b1, a, d);
   endtask

   task automatic idle();
      step(1'b0, '0, '0);
   endtask

   task automatic unlock();
      wr(22'h000555, 16'h00AA);
      wr(22'h0002AA, 16'h0055);
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      req = "R1";
      compare();
      rst_n = 1'b1;
      idle(); idle();

      // R2: program with upper address/data bits set on command cycles
      req = "R2";
      wr(22'h3FF555, 16'hC3AA); wr(22'h1552AA, 16'h7755); wr(22'h000555, 16'h00A0);
      wr(22'h12_3456, 16'hBEEF); idle(); idle();

      // R3: chip erase then sector erase
      req = "R3";
      unlock(); wr(22'h000555, 16'h0080); unlock(); wr(22'h000555, 16'h0010); idle();
      unlock(); wr(22'h000555, 16'h0080); unlock(); wr(22'h2A8123, 16'h0030); idle();

      // R4: autoselect entry, ignored writes, R6 query from autoselect, R5 returns
      req = "R4";
      unlock(); wr(22'h000555, 16'h0090); idle();
      wr(22'h000555, 16'h00AA); wr(22'h000123, 16'h0030); wr(22'h000555, 16'h0020); idle();
      req = "R6";
      wr(22'h000055, 16'h0098); idle(); wr(22'h000055, 16'h0098);
      req = "R5";
      wr(22'h000000, 16'h00F0); idle();
      wr(22'h3AB001, 16'hFFF0); idle();

      // R6: query from array, R10 non-reset write in query mode
      req = "R6";
      wr(22'h000055, 16'h0098); idle();
      req = "R10";
      wr(22'h000055, 16'h0012); idle();

      // R5: reset in the middle of an erase sequence
      req = "R5";
      unlock(); wr(22'h000555, 16'h0080); wr(22'h000777, 16'h00F0); idle();

      // R7: bypass entry and two-cycle programs
      req = "R7";
      unlock(); wr(22'h000555, 16'h0020); idle();
      wr(22'h000001, 16'h00A0); wr(22'h010002, 16'h1234);
      wr(22'h000555, 16'h00A0); wr(22'h020004, 16'h00F0); idle();

      // R9: suspend and resume, with and without busy, in bypass then array
      req = "R9";
      wr(22'h000000, 16'h00B0); wr(22'h000000, 16'h0030);
      busy = 1'b1;
      wr(22'h000100, 16'h00B0); wr(22'h000200, 16'h0030); idle();

      // R8: bypass exit
      req = "R8";
      wr(22'h000000, 16'h0090); wr(22'h000000, 16'h0000); idle();
      unlock(); wr(22'h000555, 16'h0020);
      wr(22'h000000, 16'h0090); wr(22'h000000, 16'h0001); idle();

      req = "R9";
      wr(22'h000000, 16'h00B0); idle(); wr(22'h000000, 16'h0030);
      busy = 1'b0;
      wr(22'h000000, 16'h00B0); idle();

      // R10: deviations at every position
      req = "R10";
      wr(22'h000554, 16'h00AA); wr(22'h0002AA, 16'h0055); wr(22'h000555, 16'h00A0); wr(22'h000001, 16'h0001);
      wr(22'h000555, 16'h00AA); wr(22'h0002AB, 16'h0055); wr(22'h000555, 16'h00A0);
      unlock(); wr(22'h000555, 16'h0040); wr(22'h000555, 16'h0090);
      unlock(); wr(22'h000555, 16'h0080); wr(22'h000555, 16'h0055);
      unlock(); wr(22'h000555, 16'h0080); unlock(); wr(22'h000556, 16'h0010); idle();
      unlock(); wr(22'h000555, 16'h00B0); idle();

      // R11: holds across idle and random command-heavy stream
      req = "R11";
      repeat (4) idle();
      req = "R10";
      for (int i = 0; i < 4000; i++) begin
         int sel = int'($urandom_range(0, 12));
         int asel = int'($urandom_range(0, 3));
         logic [7:0] c;
         logic [AW-1:0] a;
         case (sel)
            0: c = 8'hAA; 1: c = 8'h55; 2: c = 8'hA0; 3: c = 8'h90;
            4: c = 8'h80; 5: c = 8'h20; 6: c = 8'h10; 7: c = 8'h30;
            8: c = 8'hF0; 9: c = 8'h98; 10: c = 8'hB0; 11: c = 8'h00;
            default: c = 8'($urandom);
         endcase
         a = AW'($urandom) & 22'h3FF800;
         case (asel)
            0: a = a | 22'h555; 1: a = a | 22'h2AA; 2: a = a | 22'h055;
            default: a = AW'($urandom);
         endcase
         busy = ($urandom_range(0, 1) == 1);
         if ($urandom_range(0, 5) == 0) idle();
         else wr(a, {8'($urandom), c});
      end
      idle(); idle();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule